// File: doc/BRIEF.md
# Hysteretic PLL Lock Qualifier

This block decides whether a phase-locked loop is locked. It observes the up and down correction pulses of a phase/frequency detector and measures, in oscillator clock cycles, how long a correction was requested during each comparison cycle. A strobe input marks the last cycle of each comparison cycle. On that strobe the measured width is sorted into one of three bands: small, middle or large.

A large error drops the lock output at once. The lock output rises only after a run of consecutive small-error comparison cycles. A middle-band error leaves the output as it is but breaks the run. The gap between the two thresholds gives hysteresis, so a loop that hovers near one threshold does not toggle the indicator. The thresholds, the run length and the width of the width counter are all parameters.

Top module: `pll_lock_qualifier`

## Requirements
- R1: While `rst` is high at a clock edge, `lock_out` is low after that edge and the small-error run count is zero. After reset, `GOOD_RUN` small-error cycles are needed before `lock_out` rises.
- R2: The width of a comparison cycle is the number of clock cycles, from the cycle after the previous strobe up to and including the strobe cycle, in which `up_pulse` or `dn_pulse` is high. A cycle with both high counts once.
- R3: A strobe with width >= `UNLOCK_TH` makes `lock_out` low from the edge that ends the strobe cycle, whatever the history, and clears the run count.
- R4: A strobe with width <= `LOCK_TH` adds one to the run count. `lock_out` goes high at the edge that ends the strobe cycle of the `GOOD_RUN`-th consecutive such strobe (default 3).
- R5: A strobe with `LOCK_TH` < width < `UNLOCK_TH` leaves `lock_out` unchanged and clears the run count, so `GOOD_RUN` further small-error strobes are needed to lock.
- R6: The width saturates at 2^`CNT_W`-1 and does not wrap. A pulse longer than that is still classed as a large error.
- R7: `lock_out` changes only at the edge that ends a strobe cycle, or under reset.
- R8: While locked, further small-error strobes keep `lock_out` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| up_pulse | input | 1 | Phase detector up request |
| dn_pulse | input | 1 | Phase detector down request |
| cmp_strobe | input | 1 | High in the last cycle of each comparison cycle |
| lock_out | output | 1 | Registered lock indication, high = locked |

## Verification
The bench builds the block with `UNLOCK_TH`=10, `LOCK_TH`=6, `GOOD_RUN`=3 and `CNT_W`=5. The defaults of 9 and 8 leave the middle band empty. The 6/10 pair opens a three-value middle band (7 to 9), so the hold-and-restart behaviour of R5 can be reached, and widths exactly on either threshold can be driven. The 5-bit counter saturates at 31. A 40-cycle pulse therefore tests saturation: a wrapping counter would read 8 there and hold the lock instead of dropping it.

// File: rtl/plq_pkg.sv
package plq_pkg;
  typedef enum logic [1:0] {
    BAND_MID   = 2'd0,
    BAND_SMALL = 2'd1,
    BAND_LARGE = 2'd2
  } band_e;
endpackage

// File: rtl/plq_width_meter.sv
module plq_width_meter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_pulse,
  input  logic             dn_pulse,
  input  logic             cmp_strobe,
  output logic [CNT_W-1:0] meas_width,
  output logic [CNT_W-1:0] acc_o
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] acc_q;
  logic             active;

  assign active = up_pulse | dn_pulse;

  // width including the current cycle, held at the ceiling
  always_comb begin
    if (active && acc_q != SAT) meas_width = acc_q + 1'b1;
    else                        meas_width = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst)             acc_q <= '0;
    else if (cmp_strobe) acc_q <= '0;
    else                 acc_q <= meas_width;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/plq_band_sorter.sv
module plq_band_sorter
  import plq_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int UNLOCK_TH = 9,
  parameter int LOCK_TH   = 8
) (
  input  logic [CNT_W-1:0] width,
  output band_e            band
);
  localparam logic [CNT_W-1:0] HI_LIM = UNLOCK_TH[CNT_W-1:0];
  localparam logic [CNT_W-1:0] LO_LIM = LOCK_TH[CNT_W-1:0];

  always_comb begin
    if (width >= HI_LIM)      band = BAND_LARGE;
    else if (width <= LO_LIM) band = BAND_SMALL;
    else                      band = BAND_MID;
  end
endmodule

// File: rtl/plq_lock_fsm.sv
module plq_lock_fsm
  import plq_pkg::*;
#(
  parameter int GOOD_RUN = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  cmp_strobe,
  input  band_e band,
  output logic  lock_out
);
  localparam int RUN_W = $clog2(GOOD_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GOOD_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(GOOD_RUN);

  logic [RUN_W-1:0] run_q;
  logic             lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (cmp_strobe) begin
      unique case (band)
        BAND_LARGE: begin
          run_q  <= '0;
          lock_q <= 1'b0;
        end
        BAND_SMALL: begin
          if (run_q >= RUN_LAST) begin
            run_q  <= RUN_FULL;
            lock_q <= 1'b1;
          end else begin
            run_q  <= run_q + 1'b1;
          end
        end
        default: run_q <= '0;
      endcase
    end
  end

  assign lock_out = lock_q;
endmodule

// File: rtl/pll_lock_qualifier.sv
module pll_lock_qualifier
  import plq_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int UNLOCK_TH = 9,
  parameter int LOCK_TH   = 8,
  parameter int GOOD_RUN  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic up_pulse,
  input  logic dn_pulse,
  input  logic cmp_strobe,
  output logic lock_out
);
  logic [CNT_W-1:0] meas_width;
  logic [CNT_W-1:0] acc_val;
  band_e            band;

  plq_width_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
    .cmp_strobe(cmp_strobe), .meas_width(meas_width), .acc_o(acc_val)
  );

  plq_band_sorter #(.CNT_W(CNT_W), .UNLOCK_TH(UNLOCK_TH), .LOCK_TH(LOCK_TH)) u_sort (
    .width(meas_width), .band(band)
  );

  plq_lock_fsm #(.GOOD_RUN(GOOD_RUN)) u_fsm (
    .clk(clk), .rst(rst), .cmp_strobe(cmp_strobe), .band(band), .lock_out(lock_out)
  );
endmodule

// File: rtl/plq_checker.sv
module plq_checker #(
  parameter int CNT_W     = 5,
  parameter int UNLOCK_TH = 9,
  parameter int LOCK_TH   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             up_pulse,
  input logic             dn_pulse,
  input logic             cmp_strobe,
  input logic             lock_out,
  input logic [CNT_W-1:0] meas_width,
  input logic [CNT_W-1:0] acc_val
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !lock_out); // R1
  AST_LARGE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (cmp_strobe && int'(meas_width) >= UNLOCK_TH) |=> !lock_out); // R3
  AST_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_out) |-> $past(cmp_strobe)); // R4
  AST_MID_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cmp_strobe && int'(meas_width) > LOCK_TH && int'(meas_width) < UNLOCK_TH)
    |=> $stable(lock_out)); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!cmp_strobe && acc_val == SAT) |=> acc_val == SAT); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cmp_strobe |=> $stable(lock_out)); // R7
  AST_ACTIVE_COUNTS: assert property (@(posedge clk) disable iff (rst)
    (!cmp_strobe && (up_pulse || dn_pulse) && acc_val != SAT) |=> acc_val == $past(acc_val) + 1'b1); // R2
endmodule

bind pll_lock_qualifier plq_checker #(
  .CNT_W(CNT_W), .UNLOCK_TH(UNLOCK_TH), .LOCK_TH(LOCK_TH)
) u_chk (
  .clk(clk), .rst(rst), .up_pulse(up_pulse), .dn_pulse(dn_pulse),
  .cmp_strobe(cmp_strobe), .lock_out(lock_out),
  .meas_width(meas_width), .acc_val(acc_val)
);

// File: tb/pll_lock_qualifier_test.sv
module pll_lock_qualifier_test;
  localparam int CW = 5, HI = 10, LO = 6, RUN = 3;
  localparam int SATV = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1, up = 1'b0, dn = 1'b0, stb = 1'b0;
  logic lock_out;
  int checks = 0, fails = 0;
  string cur_req = "R1";

  int m_acc = 0, m_good = 0;
  bit m_ld = 1'b0;

  pll_lock_qualifier #(.CNT_W(CW), .UNLOCK_TH(HI), .LOCK_TH(LO), .GOOD_RUN(RUN)) uut (
    .clk(clk), .rst(rst), .up_pulse(up), .dn_pulse(dn), .cmp_strobe(stb), .lock_out(lock_out)
  );

  always #5 clk = ~clk;

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    int s;
    if (rst) begin
      m_acc = 0; m_good = 0; m_ld = 1'b0;
    end else begin
      s = m_acc + ((up || dn) ? 1 : 0);
      if (s > SATV) s = SATV;
      if (stb) begin
        m_acc = 0;
        if (s >= HI) begin m_ld = 1'b0; m_good = 0; end
        else if (s <= LO) begin m_good++; if (m_good >= RUN) m_ld = 1'b1; end
        else m_good = 0;
      end else m_acc = s;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    checks++;
    if (lock_out !== m_ld) begin
      fails++;
      $display("FAIL %s cycle compare: lock_out=%b expected %b at %0t", cur_req, lock_out, m_ld, $time);
    end
  end

  task automatic expect_ld(input bit exp, input string req);
    checks++;
    if (lock_out !== exp) begin
      fails++;
      $display("FAIL %s: lock_out=%b expected %b", req, lock_out, exp);
    end
  endtask

  // one comparison cycle: up active for wu cycles, dn for wd cycles starting at doff
  task automatic window(input int wu, input int wd, input int doff);
    int len = wu;
    if (doff + wd > len) len = doff + wd;
    len = len + 3;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      #1;
      up  = (i < wu);
      dn  = (i >= doff) && (i < doff + wd);
      stb = (i == len - 1);
    end
    @(negedge clk);
    #1;
    up = 1'b0; dn = 1'b0; stb = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #2;
    expect_ld(1'b0, "R1");

    cur_req = "R4";
    window(3, 0, 0); window(3, 0, 0); #1 expect_ld(1'b0, "R4");
    window(3, 0, 0); #1 expect_ld(1'b1, "R4");

    cur_req = "R2";
    window(5, 5, 0); #1 expect_ld(1'b1, "R2");
    window(3, 3, 3); #1 expect_ld(1'b1, "R2");
    window(4, 4, 2); #1 expect_ld(1'b1, "R2");
    window(5, 5, 5); #1 expect_ld(1'b0, "R2");

    cur_req = "R5";
    window(2, 0, 0); window(2, 0, 0); window(8, 0, 0);
    window(2, 0, 0); window(2, 0, 0); #1 expect_ld(1'b0, "R5");
    window(2, 0, 0); #1 expect_ld(1'b1, "R5");
    window(9, 0, 0); #1 expect_ld(1'b1, "R5");
    window(7, 0, 0); #1 expect_ld(1'b1, "R5");

    cur_req = "R8";
    window(6, 0, 0); window(0, 0, 0); #1 expect_ld(1'b1, "R8");

    cur_req = "R3";
    window(10, 0, 0); #1 expect_ld(1'b0, "R3");
    window(6, 0, 0); window(6, 0, 0); window(6, 0, 0); #1 expect_ld(1'b1, "R4");
    window(0, 12, 0); #1 expect_ld(1'b0, "R3");

    cur_req = "R6";
    window(1, 0, 0); window(1, 0, 0); window(1, 0, 0); #1 expect_ld(1'b1, "R6");
    window(40, 0, 0); #1 expect_ld(1'b0, "R6");

    cur_req = "R7";
    window(1, 0, 0); window(1, 0, 0); window(1, 0, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1 up = (i < 15);
    end
    #1 expect_ld(1'b1, "R7");
    @(negedge clk); #1 up = 1'b0; stb = 1'b1;
    @(negedge clk); #1 stb = 1'b0; #1 expect_ld(1'b0, "R7");

    cur_req = "R1";
    window(1, 0, 0); window(1, 0, 0); window(1, 0, 0);
    #1 rst = 1'b1;
    @(negedge clk); #2 expect_ld(1'b0, "R1");
    #1 rst = 1'b0;
    window(1, 0, 0); window(1, 0, 0); #1 expect_ld(1'b0, "R1");
    window(1, 0, 0); #1 expect_ld(1'b1, "R1");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule